// File: doc/BRIEF.md
# SPI Command-Word Register Access Slave

This block is an SPI slave (clock idles low, data sampled on the rising SCLK edge, SDO changed on the falling edge) that connects an external host to a synchronous register bank. Each transaction opens with a 16-bit command word on SDI. The command carries a 5-bit key, a direction flag and a 10-bit starting register address. A valid read command streams register contents out on SDO, one 16-bit word after another, for as long as chip select stays low. A valid write command takes each following 16-bit word from SDI and stores it. In both directions the address advances after every word.

All pins are oversampled by a faster system clock through synchronizer chains. The register bank sees a single-cycle read strobe, with data expected one system clock later, or a single-cycle write strobe with address and data. SDO comes out as a data bit plus an output enable, so a pad or the chip top can build the tri-state driver. Timing assumption: each SCLK half period spans at least four system clocks after synchronization.

Top module: `spi_cmd_regport`

## Requirements
- R1: The command word is shifted in MSB first. Its bits [15:11] are the key, bit [10] is the direction flag (1 = read, 0 = write) and bits [9:0] are the starting register address.
- R2: A command whose key differs from 0b11100 is rejected. For the rest of that chip-select period there is no register read or write strobe and the SDO enable stays low.
- R3: After a valid read command, the register at the starting address appears on SDO MSB first. Its bit 15 is driven after the falling SCLK edge that follows the 16th rising edge, so the host samples it on rising edge 17.
- R4: During a read, each further group of 16 SCLK cycles carries the register at the next address, with no new command.
- R5: The register address wraps from 0x3FF to 0x000 in both reads and writes.
- R6: The SDO enable is low during the command phase and while chip select is high. It is high from the first readback bit until chip select rises.
- R7: SDI is ignored during a readback: random SDI values change neither the returned data nor any register.
- R8: After a valid write command, each complete 16-bit word on SDI (MSB first) is written to the current address with a single-cycle strobe, and the address then advances.
- R9: A partial word cut off by chip select going high produces no write.
- R10: Raising chip select ends the transaction. A transaction cut off during its command word leaves no trace, and the next chip-select period starts with a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock, idles low |
| sdi_i | input | 1 | SPI serial data from host |
| sdo_o | output | 1 | SPI serial data to host, valid when enabled |
| sdo_oe_o | output | 1 | Output enable for the SDO driver |
| reg_addr_o | output | 10 | Register address for the current strobe |
| reg_rd_o | output | 1 | Single-cycle register read strobe |
| reg_rdata_i | input | 16 | Read data, valid the cycle after reg_rd_o |
| reg_wr_o | output | 1 | Single-cycle register write strobe |
| reg_wdata_o | output | 16 | Write data for reg_wr_o |

## Verification
The hardest case to reach is the wrap of the address pointer in the middle of a stream, because it needs a start address near the top of the space and several words in one chip-select period. Directed frames therefore start reads and writes at 0x3FE and 0x3FF and run past the boundary. Frames are also cut off partway through a data word and partway through a command word, so the discard and restart paths get exercised. Random frames then mix direction, start address, word count and SDI noise during readback, and compare against a bench-side copy of the register contents.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types for the SPI command-word register slave.
// Assumes the command layout key | direction | address, MSB first.
package spi_cmd_pkg;
    localparam int KEY_W = 5;
    localparam logic [KEY_W-1:0] CMD_KEY = 5'b11100;

    typedef enum logic [1:0] {
        PH_CMD    = 2'd0,
        PH_READ   = 2'd1,
        PH_WRITE  = 2'd2,
        PH_IGNORE = 2'd3
    } phase_t;
endpackage

// File: rtl/spi_cmd_frontend.sv
// Synchronizes CS, SCLK and SDI into the system clock domain and produces
// single-cycle SCLK edge flags. Edges are suppressed while CS is high.
// Assumes SCLK is much slower than clk (half period >= 4 clk).
module spi_cmd_frontend #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic cs_off_o,
    output logic sdi_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_V = 3'b100;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_q;

    assign raw = {cs_n_i, sclk_i, sdi_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        // Shift one pin through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_V[g]}};
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Remember the previous synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= synced[1];
    end

    assign cs_off_o = synced[2];
    assign sdi_o    = synced[0];
    assign rise_o   = synced[1] & ~sclk_q & ~synced[2];
    assign fall_o   = ~synced[1] & sclk_q & ~synced[2];
endmodule

// File: rtl/spi_cmd_ctrl.sv
// Shifts SDI in on rising SCLK edges, decodes the command word and issues
// register read/write strobes with an auto-incrementing address.
// Assumes edges arrive as single-cycle flags from the front end.
module spi_cmd_ctrl import spi_cmd_pkg::*; #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_off_i,
    input  logic              sdi_i,
    input  logic              rise_i,
    output phase_t            phase_o,
    output logic              load_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_wdata_o
);
    localparam int CMD_W = KEY_W + 1 + ADDR_W;
    localparam int SH_W  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(SH_W) + 1;

    phase_t            phase_q;
    logic [SH_W-1:0]   sh_q;
    logic [SH_W-1:0]   sh_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_c;
    logic [ADDR_W-1:0] ptr_q;
    logic [KEY_W-1:0]  key_c;
    logic              dir_c;
    logic [ADDR_W-1:0] adr_c;

    // Next shift-register value and fields of a just-completed command.
    always_comb begin
        sh_nxt = {sh_q[SH_W-2:0], sdi_i};
        key_c  = sh_nxt[CMD_W-1 -: KEY_W];
        dir_c  = sh_nxt[ADDR_W];
        adr_c  = sh_nxt[ADDR_W-1:0];
        last_c = (phase_q == PH_CMD) ? CNT_W'(CMD_W - 1) : CNT_W'(DATA_W - 1);
    end

    // Bit counting, phase sequencing and register strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_off_i) begin
            phase_q     <= PH_CMD;
            sh_q        <= '0;
            cnt_q       <= '0;
            ptr_q       <= '0;
            load_o      <= 1'b0;
            reg_rd_o    <= 1'b0;
            reg_wr_o    <= 1'b0;
            if (!rst_n) begin
                reg_addr_o  <= '0;
                reg_wdata_o <= '0;
            end
        end else begin
            reg_rd_o <= 1'b0;
            reg_wr_o <= 1'b0;
            load_o   <= reg_rd_o;
            if (rise_i) begin
                sh_q <= sh_nxt;
                if (cnt_q == last_c) begin
                    cnt_q <= '0;
                    unique case (phase_q)
                        PH_CMD: begin
                            if (key_c != CMD_KEY) begin
                                phase_q <= PH_IGNORE;
                            end else if (dir_c) begin
                                phase_q    <= PH_READ;
                                reg_rd_o   <= 1'b1;
                                reg_addr_o <= adr_c;
                                ptr_q      <= adr_c + 1'b1;
                            end else begin
                                phase_q <= PH_WRITE;
                                ptr_q   <= adr_c;
                            end
                        end
                        PH_READ: begin
                            reg_rd_o   <= 1'b1;
                            reg_addr_o <= ptr_q;
                            ptr_q      <= ptr_q + 1'b1;
                        end
                        PH_WRITE: begin
                            reg_wr_o    <= 1'b1;
                            reg_addr_o  <= ptr_q;
                            reg_wdata_o <= sh_nxt[DATA_W-1:0];
                            ptr_q       <= ptr_q + 1'b1;
                        end
                        default: ;
                    endcase
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/spi_cmd_sdo.sv
// Holds the readback word and shifts it out MSB first on falling SCLK
// edges during a read; owns the SDO output enable.
// Assumes a load never coincides with a falling edge (SCLK timing).
module spi_cmd_sdo import spi_cmd_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_off_i,
    input  logic              fall_i,
    input  phase_t            phase_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              sdo_o,
    output logic              oe_o
);
    logic [DATA_W-1:0] word_q;

    // Capture read data, then present one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_off_i) begin
            word_q <= '0;
            sdo_o  <= 1'b0;
            oe_o   <= 1'b0;
        end else if (load_i) begin
            word_q <= rdata_i;
        end else if (fall_i && phase_i == PH_READ) begin
            sdo_o  <= word_q[DATA_W-1];
            word_q <= {word_q[DATA_W-2:0], 1'b0};
            oe_o   <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_cmd_regport.sv
// Top of the SPI command-word register access slave: front end, command
// controller and SDO shifter. Register bank returns read data one clk
// after the read strobe.
module spi_cmd_regport import spi_cmd_pkg::*; #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_rd_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_wdata_o
);
    logic   cs_off;
    logic   sdi_s;
    logic   rise;
    logic   fall;
    logic   load;
    phase_t phase;

    spi_cmd_frontend #(.STAGES(SYNC_STAGES)) u_fe (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i),
        .sdi_i(sdi_i), .cs_off_o(cs_off), .sdi_o(sdi_s),
        .rise_o(rise), .fall_o(fall)
    );

    spi_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_off_i(cs_off), .sdi_i(sdi_s),
        .rise_i(rise), .phase_o(phase), .load_o(load),
        .reg_addr_o(reg_addr_o), .reg_rd_o(reg_rd_o),
        .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o)
    );

    spi_cmd_sdo #(.DATA_W(DATA_W)) u_sdo (
        .clk(clk), .rst_n(rst_n), .cs_off_i(cs_off), .fall_i(fall),
        .phase_i(phase), .load_i(load), .rdata_i(reg_rdata_i),
        .sdo_o(sdo_o), .oe_o(sdo_oe_o)
    );
endmodule

// File: rtl/spi_cmd_regport_chk.sv
// Protocol checker for spi_cmd_regport, attached with bind below.
module spi_cmd_regport_chk import spi_cmd_pkg::*; #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_off,
    input phase_t            phase,
    input logic              reg_rd_o,
    input logic              reg_wr_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic              sdo_oe_o
);
    logic              have_prev;
    logic [ADDR_W-1:0] prev_addr;

    // Track the last read address inside one chip-select period.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_off) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (reg_rd_o) begin
            have_prev <= 1'b1;
            prev_addr <= reg_addr_o;
        end
    end

    p_rdwr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_o && reg_wr_o));
    p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);
    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);
    p_oe_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_off |=> !sdo_oe_o);
    p_cmd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD) |-> !sdo_oe_o);
    p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |-> (!reg_rd_o && !reg_wr_o && !sdo_oe_o));
    // R4 and R5: consecutive reads step by one, wrapping at the top.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_o && have_prev) |-> (reg_addr_o == ADDR_W'(prev_addr + 1'b1)));
endmodule

bind spi_cmd_regport spi_cmd_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_off(cs_off), .phase(phase),
    .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
    .sdo_oe_o(sdo_oe_o)
);

// File: tb/sim_spi_cmd_regport.sv
module sim_spi_cmd_regport;
    localparam int CLK_NS = 10;
    localparam int HALF   = 8 * CLK_NS;
    localparam int NREG   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe, reg_rd, reg_wr;
    logic [9:0]  reg_addr;
    logic [15:0] reg_rdata = '0;
    logic [15:0] reg_wdata;

    logic [15:0] mem [NREG];
    logic [15:0] exp_mem [NREG];
    logic        pre_we = 1'b0;
    logic [9:0]  pre_addr = '0;
    logic [15:0] pre_data = '0;
    int          rd_cnt = 0, wr_cnt = 0;
    int          errs = 0, checks = 0;
    logic [15:0] wbuf [8];
    logic [15:0] rbuf [8];
    int          oe_bad;

    spi_cmd_regport u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_addr_o(reg_addr),
        .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata), .reg_wr_o(reg_wr),
        .reg_wdata_o(reg_wdata)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Register bank model with one-cycle read latency.
    always @(posedge clk) begin
        if (pre_we) mem[pre_addr] <= pre_data;
        else begin
            if (reg_wr) mem[reg_addr] <= reg_wdata;
            if (reg_rd) reg_rdata <= mem[reg_addr];
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (reg_wr) wr_cnt <= wr_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one chip-select period of nbits SCLK cycles; capture SDO.
    task automatic frame(input logic [15:0] cmd, input int nbits, input bit exp_oe);
        bit wmode;
        wmode = (cmd[10] == 1'b0);
        oe_bad = 0;
        for (int k = 0; k < 8; k++) rbuf[k] = '0;
        cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i < 16) sdi = cmd[15-i];
            else if (wmode && (i-16)/16 < 8) sdi = wbuf[(i-16)/16][15-((i-16)%16)];
            else sdi = 1'($urandom);
            #(HALF);
            if (sdo_oe !== ((i >= 16) && exp_oe)) oe_bad++;
            if (i >= 16 && (i-16)/16 < 8) rbuf[(i-16)/16][15-((i-16)%16)] = sdo;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
        #(HALF);
        cs_n = 1'b1;
        #(6*CLK_NS);
        if (sdo_oe !== 1'b0) oe_bad++;
        #(4*CLK_NS);
    endtask

    task automatic do_read(input logic [9:0] addr, input int nw, input string tag);
        int w0;
        w0 = wr_cnt;
        frame({5'b11100, 1'b1, addr}, 16 + 16*nw, 1'b1);
        for (int k = 0; k < nw; k++)
            chk(tag, rbuf[k], exp_mem[(int'(addr) + k) % NREG]);
        chk("R6 sdo enable window", oe_bad, 0);
        chk("R7 no write during read", wr_cnt - w0, 0);
    endtask

    task automatic do_write(input logic [9:0] addr, input int nw, input int extra, input string tag);
        int w0;
        w0 = wr_cnt;
        for (int k = 0; k < 8; k++) wbuf[k] = 16'($urandom);
        frame({5'b11100, 1'b0, addr}, 16 + 16*nw + extra, 1'b0);
        for (int k = 0; k < nw; k++) begin
            exp_mem[(int'(addr) + k) % NREG] = wbuf[k];
            chk(tag, mem[(int'(addr) + k) % NREG], wbuf[k]);
        end
        chk(extra > 0 ? "R9 strobes for complete words only" : "R8 write strobe count",
            wr_cnt - w0, nw);
        chk("R6 no enable in write", oe_bad, 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int r0, w0;
        void'($urandom(32'd5150));
        // Preload the bank during reset.
        for (int a = 0; a < NREG; a++) begin
            @(negedge clk);
            pre_we = 1'b1;
            pre_addr = 10'(a);
            pre_data = 16'($urandom);
            exp_mem[a] = pre_data;
        end
        @(negedge clk);
        pre_we = 1'b0;
        #(4*CLK_NS);
        chk("R6 reset enable", sdo_oe, 0);
        chk("R10 reset read strobe", reg_rd, 0);
        chk("R10 reset write strobe", reg_wr, 0);
        rst_n = 1'b1;
        #(10*CLK_NS);

        // R1 R3 R4: field decode and streaming.
        do_read(10'h2AA, 1, "R1 R3 first word");
        do_read(10'h010, 3, "R4 stream");
        // R5: wrap in a read.
        do_read(10'h3FE, 4, "R5 read wrap");
        // R2: wrong key ignored.
        r0 = rd_cnt; w0 = wr_cnt;
        frame({5'b11101, 1'b1, 10'h020}, 64, 1'b0);
        chk("R2 no reads", rd_cnt - r0, 0);
        chk("R2 no writes", wr_cnt - w0, 0);
        chk("R2 enable low", oe_bad, 0);
        r0 = rd_cnt; w0 = wr_cnt;
        frame({5'b01100, 1'b0, 10'h020}, 48, 1'b0);
        chk("R2 bad key write", wr_cnt - w0, 0);
        // R5 R8: write across the wrap, then read it back.
        do_write(10'h3FF, 2, 0, "R5 R8 write wrap");
        do_read(10'h3FF, 2, "R8 readback");
        // R9: partial word discarded.
        do_write(10'h100, 1, 7, "R9 full word kept");
        do_read(10'h101, 1, "R9 neighbour untouched");
        // R10: cut command, then a fresh transaction.
        r0 = rd_cnt; w0 = wr_cnt;
        frame({5'b11100, 1'b1, 10'h155}, 9, 1'b0);
        chk("R10 cut command no read", rd_cnt - r0, 0);
        chk("R10 cut command no write", wr_cnt - w0, 0);
        do_read(10'h0C3, 2, "R10 fresh frame");

        // Random mix.
        for (int t = 0; t < 24; t++) begin
            logic [9:0] a;
            int nw;
            a  = 10'($urandom);
            if (t % 4 == 0) a = 10'h3FC + 10'($urandom_range(0, 3));
            nw = $urandom_range(1, 4);
            if ($urandom_range(0, 1) == 1) do_read(a, nw, "R4 R7 random read");
            else do_write(a, nw, 0, "R8 random write");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule